// File: doc/BRIEF.md
# Delayed Write Completion Tracker

This block follows a single delayed write that a bridge has taken from an initiator and is now trying to deliver on the far bus. Every time the far-side target ends an attempt, the block records the outcome. A retry or a failed attempt leaves the write pending. A normal end, a disconnect or an abort fixes the answer that the original initiator will get the next time it comes back.

While the write is pending, the block asks for further attempts and answers each initiator retry with a retry. An attempt counter limits how long this can go on. A one-bit select chooses one of two limits, 2^LO_LOG or 2^HI_LOG, which default to 2^24 and 2^32. If the limit is reached, the write is dropped. A system-error request pulse is then raised if the error enable is set and the non-delivery event is not masked.

The block also keeps two sticky target-abort status bits, one for each side of the bridge. Software clears each of them with a write-one-to-clear.

Top module: `dwt_top`

## Requirements
- R1: While a write is pending, `attempt_req` is 1. A retry termination (`term_code`=1) keeps it pending. An `init_req` while pending gives `resp_valid`=1 with `resp_code`=0 (retry) on the next cycle.
- R2: A normal termination (`term_code`=0) or a disconnect termination (`term_code`=2) completes the write. The next `init_req` then gets `resp_code`=1 (disconnect after first data) if `accept_multi` was 1 at acceptance, or `resp_code`=2 (complete) if it was 0. After that, `attempt_req` is 0.
- R3: An abort termination (`term_code`=3) while pending sets both `sta_recv_abort` and `sta_sig_abort` on the next cycle. The next `init_req` then gets `resp_code`=3.
- R4: The status bits are sticky. `w1c_recv` clears only `sta_recv_abort`, and `w1c_sig` clears only `sta_sig_abort`. If a set and a clear arrive in the same cycle, the set wins.
- R5: With `limit_sel`=0, the write fails on the 2^LO_LOG-th consecutive retry termination. With `limit_sel`=1, it fails on the 2^HI_LOG-th. On failure `attempt_req` drops and the write is discarded, so a later `init_req` gets no response.
- R6: `serr_pulse` is 1 for exactly one cycle, the cycle after the failing retry. It is raised only when `serr_en`=1 and `nodeliv_dis`=0.
- R7: The attempt counter clears when a new write is accepted and when a final response is delivered, so each write gets the full limit.
- R8: After reset all outputs are 0. Terminations that arrive while no write is pending have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | New delayed write accepted (taken only when idle) |
| accept_multi | input | 1 | Initiator requested more than one data phase |
| term_valid | input | 1 | Target attempt ended this cycle |
| term_code | input | 2 | 0 normal, 1 retry, 2 disconnect, 3 abort |
| init_req | input | 1 | Original initiator retries the write |
| limit_sel | input | 1 | 0 selects 2^LO_LOG attempts, 1 selects 2^HI_LOG |
| serr_en | input | 1 | System-error reporting enable |
| nodeliv_dis | input | 1 | Masks the non-delivery system-error event |
| w1c_recv | input | 1 | Write-one-to-clear for received-abort bit |
| w1c_sig | input | 1 | Write-one-to-clear for signaled-abort bit |
| attempt_req | output | 1 | Write pending; keep attempting on target bus |
| resp_valid | output | 1 | Response to initiator valid |
| resp_code | output | 2 | 0 retry, 1 disconnect after first data, 2 complete, 3 target abort |
| sta_recv_abort | output | 1 | Received-target-abort status (target side) |
| sta_sig_abort | output | 1 | Signaled-target-abort status (initiator side) |
| serr_pulse | output | 1 | One-cycle system-error request |

## Verification
A wrong tracker state shows up on the cycle after the next `init_req`: the initiator gets a retry where it should get a final answer, or the reverse, or no answer at all. A wrong attempt count only appears when a write reaches the end of its limit. At that point `serr_pulse` and the drop of `attempt_req` come one retry too early or too late, so the bench runs writes to the exact limit with small limit parameters. A status bit that is set or cleared wrongly is visible on the very next cycle.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    typedef enum logic [1:0] {
        TERM_NORMAL = 2'd0,
        TERM_RETRY  = 2'd1,
        TERM_DISC   = 2'd2,
        TERM_ABORT  = 2'd3
    } term_e;

    typedef enum logic [1:0] {
        RSP_RETRY      = 2'd0,
        RSP_DISC_FIRST = 2'd1,
        RSP_COMPLETE   = 2'd2,
        RSP_TABORT     = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PEND     = 2'd1,
        ST_DONE_OK  = 2'd2,
        ST_DONE_ABT = 2'd3
    } st_e;

    typedef struct packed {
        logic  valid;
        term_e code;
    } term_t;

    // Final answer for a write that finished on the target bus
    function automatic rsp_e final_rsp(st_e st, logic multi);
        if (st == ST_DONE_ABT) return RSP_TABORT;
        return multi ? RSP_DISC_FIRST : RSP_COMPLETE;
    endfunction

endpackage

// File: rtl/dwt_attempt_ctr.sv
module dwt_attempt_ctr #(
    parameter int CNT_W  = 32,
    parameter int LO_LOG = 24,
    parameter int HI_LOG = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic limit_sel,
    output logic last
);
    localparam logic [CNT_W-1:0] LIM_LO_M1 = CNT_W'((64'd1 << LO_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] LIM_HI_M1 = CNT_W'((64'd1 << HI_LOG) - 64'd1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;

    assign lim_m1 = limit_sel ? LIM_HI_M1 : LIM_LO_M1;
    // >= covers a limit lowered in the middle of a write
    assign last   = (cnt >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R5

endmodule

// File: rtl/dwt_fsm.sv
module dwt_fsm
    import dwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  accept_multi,
    input  term_t term,
    input  logic  init_req,
    input  logic  last,
    output logic  attempt_req,
    output logic  cnt_inc,
    output logic  cnt_clr,
    output logic  fail,
    output logic  abort_set,
    output logic  resp_valid,
    output rsp_e  resp_code
);
    st_e  st;
    logic multi_q;
    logic pend, done, tv_retry;

    assign pend      = (st == ST_PEND);
    assign done      = (st == ST_DONE_OK) || (st == ST_DONE_ABT);
    assign tv_retry  = pend && term.valid && (term.code == TERM_RETRY);
    assign cnt_inc   = tv_retry && !last;
    assign fail      = tv_retry && last;
    assign abort_set = pend && term.valid && (term.code == TERM_ABORT);
    assign cnt_clr   = ((st == ST_IDLE) && accept) || (done && init_req) || fail;
    assign attempt_req = pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            multi_q    <= 1'b0;
            resp_valid <= 1'b0;
            resp_code  <= RSP_RETRY;
        end else begin
            resp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st      <= ST_PEND;
                        multi_q <= accept_multi;
                    end
                end
                ST_PEND: begin
                    if (init_req) begin
                        resp_valid <= 1'b1;
                        resp_code  <= RSP_RETRY;
                    end
                    if (term.valid) begin
                        case (term.code)
                            TERM_NORMAL, TERM_DISC: st <= ST_DONE_OK;
                            TERM_ABORT:             st <= ST_DONE_ABT;
                            default:                if (last) st <= ST_IDLE;
                        endcase
                    end
                end
                default: begin
                    if (init_req) begin
                        resp_valid <= 1'b1;
                        resp_code  <= final_rsp(st, multi_q);
                        st         <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(init_req)); // R1
    AST_FAIL_DROP: assert property (@(posedge clk) disable iff (rst)
        fail |=> !attempt_req); // R5
    AST_ABORT_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE_ABT && init_req) |=> (resp_valid && resp_code == RSP_TABORT)); // R3

endmodule

// File: rtl/dwt_status.sv
module dwt_status (
    input  logic clk,
    input  logic rst,
    input  logic abort_set,
    input  logic fail,
    input  logic serr_en,
    input  logic nodeliv_dis,
    input  logic w1c_recv,
    input  logic w1c_sig,
    output logic sta_recv_abort,
    output logic sta_sig_abort,
    output logic serr_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sta_recv_abort <= 1'b0;
            sta_sig_abort  <= 1'b0;
            serr_pulse     <= 1'b0;
        end else begin
            if (abort_set)     sta_recv_abort <= 1'b1;
            else if (w1c_recv) sta_recv_abort <= 1'b0;
            if (abort_set)     sta_sig_abort  <= 1'b1;
            else if (w1c_sig)  sta_sig_abort  <= 1'b0;
            serr_pulse <= fail && serr_en && !nodeliv_dis;
        end
    end

    AST_SERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        serr_pulse |=> !serr_pulse); // R6
    AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
        serr_pulse |-> $past(fail && serr_en && !nodeliv_dis)); // R6
    AST_RECV_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(sta_recv_abort) && !$past(w1c_recv)) |-> sta_recv_abort); // R4
    AST_SIG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(sta_sig_abort) && !$past(w1c_sig)) |-> sta_sig_abort); // R4

endmodule

// File: rtl/dwt_top.sv
module dwt_top
    import dwt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LO_LOG = 24,
    parameter int HI_LOG = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       accept_multi,
    input  logic       term_valid,
    input  logic [1:0] term_code,
    input  logic       init_req,
    input  logic       limit_sel,
    input  logic       serr_en,
    input  logic       nodeliv_dis,
    input  logic       w1c_recv,
    input  logic       w1c_sig,
    output logic       attempt_req,
    output logic       resp_valid,
    output logic [1:0] resp_code,
    output logic       sta_recv_abort,
    output logic       sta_sig_abort,
    output logic       serr_pulse
);
    term_t term;
    rsp_e  rsp;
    logic  last, cnt_inc, cnt_clr, fail, abort_set;

    assign term.valid = term_valid;
    assign term.code  = term_e'(term_code);
    assign resp_code  = rsp;

    dwt_attempt_ctr #(.CNT_W(CNT_W), .LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_ctr (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .limit_sel(limit_sel), .last(last)
    );

    dwt_fsm u_fsm (
        .clk(clk), .rst(rst), .accept(accept), .accept_multi(accept_multi),
        .term(term), .init_req(init_req), .last(last),
        .attempt_req(attempt_req), .cnt_inc(cnt_inc), .cnt_clr(cnt_clr),
        .fail(fail), .abort_set(abort_set),
        .resp_valid(resp_valid), .resp_code(rsp)
    );

    dwt_status u_sta (
        .clk(clk), .rst(rst), .abort_set(abort_set), .fail(fail),
        .serr_en(serr_en), .nodeliv_dis(nodeliv_dis),
        .w1c_recv(w1c_recv), .w1c_sig(w1c_sig),
        .sta_recv_abort(sta_recv_abort), .sta_sig_abort(sta_sig_abort),
        .serr_pulse(serr_pulse)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!attempt_req && term_valid && term_code == 2'd3 && !sta_recv_abort) |=> !sta_recv_abort); // R8

endmodule

// File: tb/sim_dwt_top.sv
module sim_dwt_top;
    localparam int LO = 3;
    localparam int HI = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic accept = 0, accept_multi = 0, term_valid = 0, init_req = 0;
    logic [1:0] term_code = 0;
    logic limit_sel = 0, serr_en = 1, nodeliv_dis = 0, w1c_recv = 0, w1c_sig = 0;
    logic attempt_req, resp_valid, sta_recv_abort, sta_sig_abort, serr_pulse;
    logic [1:0] resp_code;
    int total = 0;
    int bad = 0;

    always #10ns clk = ~clk;

    dwt_top #(.CNT_W(8), .LO_LOG(LO), .HI_LOG(HI)) u0 (
        .clk(clk), .rst(rst), .accept(accept), .accept_multi(accept_multi),
        .term_valid(term_valid), .term_code(term_code), .init_req(init_req),
        .limit_sel(limit_sel), .serr_en(serr_en), .nodeliv_dis(nodeliv_dis),
        .w1c_recv(w1c_recv), .w1c_sig(w1c_sig), .attempt_req(attempt_req),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .sta_recv_abort(sta_recv_abort), .sta_sig_abort(sta_sig_abort),
        .serr_pulse(serr_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start(input logic multi);
        accept = 1; accept_multi = multi;
        @(negedge clk);
        accept = 0;
    endtask

    task automatic term(input logic [1:0] c);
        term_valid = 1; term_code = c;
        @(negedge clk);
        term_valid = 0;
    endtask

    task automatic ask(input string tag, input int exp_v, input int exp_c);
        init_req = 1;
        @(negedge clk);
        init_req = 0;
        chk({tag, " resp_valid"}, resp_valid, exp_v);
        if (exp_v == 1) chk({tag, " resp_code"}, resp_code, exp_c);
    endtask

    task automatic t_reset();
        chk("R8 reset attempt_req", attempt_req, 0);
        chk("R8 reset resp_valid", resp_valid, 0);
        chk("R8 reset status", {sta_recv_abort, sta_sig_abort}, 0);
        chk("R8 reset serr", serr_pulse, 0);
        term(2'd3);
        chk("R8 idle abort ignored", {sta_recv_abort, sta_sig_abort}, 0);
        ask("R8 idle init_req", 0, 0);
    endtask

    task automatic t_retry();
        start(1);
        chk("R1 pending", attempt_req, 1);
        term(2'd1);
        chk("R1 still pending", attempt_req, 1);
        ask("R1 retry answer", 1, 0);
        term(2'd0);
        ask("R2 normal multi", 1, 1);
        chk("R2 done", attempt_req, 0);
    endtask

    task automatic t_complete();
        start(0);
        term(2'd0);
        ask("R2 normal single", 1, 2);
        start(1);
        term(2'd2);
        ask("R2 disc multi", 1, 1);
        start(0);
        term(2'd2);
        ask("R2 disc single", 1, 2);
    endtask

    task automatic t_abort();
        start(1);
        term(2'd3);
        chk("R3 recv set", sta_recv_abort, 1);
        chk("R3 sig set", sta_sig_abort, 1);
        ask("R3 abort answer", 1, 3);
        w1c_recv = 1; @(negedge clk); w1c_recv = 0;
        chk("R4 recv cleared", sta_recv_abort, 0);
        chk("R4 sig kept", sta_sig_abort, 1);
        w1c_sig = 1; @(negedge clk); w1c_sig = 0;
        chk("R4 sig cleared", sta_sig_abort, 0);
        start(0);
        w1c_recv = 1; w1c_sig = 1;
        term(2'd3);
        w1c_recv = 0; w1c_sig = 0;
        chk("R4 set wins", {sta_recv_abort, sta_sig_abort}, 3);
        ask("R3 abort single", 1, 3);
        w1c_recv = 1; w1c_sig = 1; @(negedge clk); w1c_recv = 0; w1c_sig = 0;
    endtask

    task automatic t_limit(input logic sel, input logic en, input logic dis, input int exp_serr);
        int n;
        n = sel ? (1 << HI) : (1 << LO);
        limit_sel = sel; serr_en = en; nodeliv_dis = dis;
        start(0);
        for (int i = 1; i < n; i++) begin
            term(2'd1);
            chk("R5 below limit pending", attempt_req, 1);
            chk("R6 no early serr", serr_pulse, 0);
        end
        term(2'd1);
        chk("R5 limit dropped", attempt_req, 0);
        chk("R6 serr at limit", serr_pulse, exp_serr);
        @(negedge clk);
        chk("R6 serr one cycle", serr_pulse, 0);
        ask("R5 discarded no answer", 0, 0);
        limit_sel = 0; serr_en = 1; nodeliv_dis = 0;
    endtask

    task automatic t_clear();
        start(0);
        for (int i = 0; i < 5; i++) term(2'd1);
        term(2'd0);
        ask("R7 deliver", 1, 2);
        start(0);
        for (int i = 1; i < (1 << LO); i++) term(2'd1);
        chk("R7 full limit after clear", attempt_req, 1);
        term(2'd1);
        chk("R7 fails at limit", attempt_req, 0);
        chk("R7 serr", serr_pulse, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_retry();
        t_complete();
        t_abort();
        t_limit(0, 1, 0, 1);
        t_limit(1, 1, 0, 1);
        t_limit(0, 0, 0, 0);
        t_limit(0, 1, 1, 0);
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule